// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block sits on the host side of an 8-bit parallel bus that feeds a dual-channel, double-buffered digital-to-analog converter. A client hands it one request at a time over a valid/ready handshake. A request either writes a byte into one of the two channel registers, optionally followed by a strobe that makes both outputs take their new codes at once, or it issues only a clear strobe. The block produces the channel select, the active-low chip select, the active-low write, the data bus, the active-low load strobe and the active-low clear strobe.

Every timing limit of the bus is given in picoseconds. The limits are write low time, data setup before the write rising edge, data hold after it, the gap from the write rising edge to the load falling edge, the load width and the clear width. The block turns each limit into a number of system clock cycles, ceil(limit / clock period) with at least one cycle, and counts them. To update both channels together, the client writes channel A with the load flag clear and then writes channel B with the load flag set. The single load pulse then follows the second write.

Top module: `pdac_write_seq`

## Requirements
- R1: During and straight after synchronous reset, chip select, write, load and clear are all high (inactive), `req_ready` is 1 and `busy` is 0.
- R2: Each write request drives `dac_wr_n` low for exactly max(cyc(T_WR_PS), cyc(T_DSU_PS)) cycles, where cyc(t) = max(1, ceil(t / CLK_PS)). This is 2 cycles at the defaults.
- R3: The data byte captured at acceptance appears on `dac_data` from the first cycle of the write low phase. It stays unchanged until the write rising edge.
- R4: `dac_sel` equals the request's channel bit (0 = channel A, 1 = channel B) throughout the write low phase.
- R5: `dac_cs_n` is low in exactly the cycles in which `dac_wr_n` is low, and high otherwise.
- R6: After the write rising edge, `dac_data` stays unchanged for cyc(T_DH_PS) further cycles (1 at the defaults).
- R7: A write with the load flag set drives `dac_ldac_n` low exactly max(cyc(T_W2L_PS), cyc(T_DH_PS)) cycles after the write rising edge. A write with the load flag clear issues no load pulse.
- R8: A load pulse lasts exactly cyc(T_LD_PS) cycles.
- R9: A request with the clear flag set drives `dac_clr_n` low for exactly cyc(T_CLR_PS) cycles. It produces no write, chip select or load activity, and at most one of write, load and clear is ever low.
- R10: From acceptance, `req_ready` stays low for exactly the length of the request's sequence: the write low time plus the hold time, plus the gap and the load width when loading, or the clear width for a clear request.
- R11: `busy` is always the inverse of `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_chan | input | 1 | Target channel: 0 = A, 1 = B |
| req_data | input | DATA_W | Byte to write |
| req_load | input | 1 | Pulse the load strobe after this write |
| req_clear | input | 1 | Issue only a clear pulse |
| busy | output | 1 | A sequence is in progress |
| dac_sel | output | 1 | Channel select on the bus |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_wr_n | output | 1 | Write strobe, active low |
| dac_data | output | DATA_W | Parallel data bus |
| dac_ldac_n | output | 1 | Simultaneous update strobe, active low |
| dac_clr_n | output | 1 | Clear strobe, active low |

## Verification
A wrong state or a wrong timer load value shows up at the ports within the same request: a strobe one cycle too short or too long, a load pulse in the wrong place, or `req_ready` returning early or late. The bench records every cycle of each sequence at the pins and compares it with a waveform built from the cycle counts above. A fault is therefore reported on the first request that exercises the faulty path. A captured byte or channel that is wrong appears on the bus during that request's write low phase.

// File: rtl/pdac_seq_pkg.sv
package pdac_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WLOW,
        ST_WHOLD,
        ST_LGAP,
        ST_LLOW,
        ST_CLOW
    } seq_st_e;

    typedef struct packed {
        logic chan;
        logic load;
        logic clear;
    } req_ctl_t;

    function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pdac_seq_timer.sv
module pdac_seq_timer #(
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)) else $error("timer"); // R10

endmodule

// File: rtl/pdac_seq_ctrl.sv
module pdac_seq_ctrl
    import pdac_seq_pkg::*;
#(
    parameter int unsigned N_WL  = 2,
    parameter int unsigned N_H   = 1,
    parameter int unsigned N_GAP = 1,
    parameter int unsigned N_LD  = 2,
    parameter int unsigned N_CLR = 2,
    parameter int unsigned CW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  req_ctl_t      req_ctl,
    input  logic          tmr_done,
    output seq_st_e       state,
    output logic          accept,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val
);
    seq_st_e st_nx;
    logic    load_q;

    assign accept = (state == ST_IDLE) && req_valid;

    always_comb begin
        st_nx    = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_IDLE: if (req_valid) begin
                tmr_load = 1'b1;
                if (req_ctl.clear) begin
                    st_nx   = ST_CLOW;
                    tmr_val = CW'(N_CLR - 1);
                end else begin
                    st_nx   = ST_WLOW;
                    tmr_val = CW'(N_WL - 1);
                end
            end
            ST_WLOW: if (tmr_done) begin
                st_nx    = ST_WHOLD;
                tmr_load = 1'b1;
                tmr_val  = CW'(N_H - 1);
            end
            ST_WHOLD: if (tmr_done) begin
                if (!load_q) begin
                    st_nx = ST_IDLE;
                end else if (N_GAP != 0) begin
                    st_nx    = ST_LGAP;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(N_GAP - 1);
                end else begin
                    st_nx    = ST_LLOW;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(N_LD - 1);
                end
            end
            ST_LGAP: if (tmr_done) begin
                st_nx    = ST_LLOW;
                tmr_load = 1'b1;
                tmr_val  = CW'(N_LD - 1);
            end
            ST_LLOW: if (tmr_done) st_nx = ST_IDLE;
            ST_CLOW: if (tmr_done) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            load_q <= 1'b0;
        end else begin
            state <= st_nx;
            if (accept)
                load_q <= req_ctl.load && !req_ctl.clear;
        end
    end

    AST_LOAD_ONLY_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LLOW && $past(state) != ST_LLOW) |->
        ($past(state) == ST_LGAP || $past(state) == ST_WHOLD)) else $error("ldac order"); // R7

endmodule

// File: rtl/pdac_seq_bus.sv
module pdac_seq_bus
    import pdac_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_st_e           state,
    input  logic              accept,
    input  req_ctl_t          req_ctl,
    input  logic [DATA_W-1:0] req_data,
    output logic              dac_sel,
    output logic              dac_cs_n,
    output logic              dac_wr_n,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_ldac_n,
    output logic              dac_clr_n
);
    logic              sel_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            data_q <= '0;
        end else if (accept && !req_ctl.clear) begin
            sel_q  <= req_ctl.chan;
            data_q <= req_data;
        end
    end

    assign dac_sel    = sel_q;
    assign dac_data   = data_q;
    assign dac_wr_n   = (state != ST_WLOW);
    assign dac_cs_n   = (state != ST_WLOW);
    assign dac_ldac_n = (state != ST_LLOW);
    assign dac_clr_n  = (state != ST_CLOW);

    AST_DATA_HELD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_wr_n) |-> $stable(dac_data)) else $error("data hold"); // R6
    AST_LDAC_AFTER_WR_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_ldac_n) |-> (dac_wr_n && $past(dac_wr_n))) else $error("ldac setup"); // R7
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!dac_wr_n, !dac_ldac_n, !dac_clr_n})) else $error("strobes"); // R9

endmodule

// File: rtl/pdac_write_seq.sv
module pdac_write_seq
    import pdac_seq_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_PS    = 10000,
    parameter int unsigned T_WR_PS   = 20000,
    parameter int unsigned T_DSU_PS  = 15000,
    parameter int unsigned T_DH_PS   = 4500,
    parameter int unsigned T_W2L_PS  = 20000,
    parameter int unsigned T_LD_PS   = 20000,
    parameter int unsigned T_CLR_PS  = 20000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_chan,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_load,
    input  logic              req_clear,
    output logic              busy,
    output logic              dac_sel,
    output logic              dac_cs_n,
    output logic              dac_wr_n,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_ldac_n,
    output logic              dac_clr_n
);
    localparam int unsigned N_WL  = umax(ps_to_cyc(T_WR_PS, CLK_PS), ps_to_cyc(T_DSU_PS, CLK_PS));
    localparam int unsigned N_H   = ps_to_cyc(T_DH_PS, CLK_PS);
    localparam int unsigned N_W2L = umax(ps_to_cyc(T_W2L_PS, CLK_PS), N_H);
    localparam int unsigned N_GAP = N_W2L - N_H;
    localparam int unsigned N_LD  = ps_to_cyc(T_LD_PS, CLK_PS);
    localparam int unsigned N_CLR = ps_to_cyc(T_CLR_PS, CLK_PS);
    localparam int unsigned N_MAX = umax(umax(N_WL, N_H), umax(umax(N_GAP, N_LD), N_CLR));
    localparam int unsigned CW    = (N_MAX < 2) ? 1 : $clog2(N_MAX);

    seq_st_e       state;
    req_ctl_t      req_ctl;
    logic          accept;
    logic          tmr_load;
    logic          tmr_done;
    logic [CW-1:0] tmr_val;

    assign req_ctl = '{chan: req_chan, load: req_load, clear: req_clear};

    pdac_seq_ctrl #(
        .N_WL(N_WL), .N_H(N_H), .N_GAP(N_GAP), .N_LD(N_LD), .N_CLR(N_CLR), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ctl(req_ctl),
        .tmr_done(tmr_done), .state(state), .accept(accept),
        .tmr_load(tmr_load), .tmr_val(tmr_val)
    );

    pdac_seq_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    pdac_seq_bus #(.DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst(rst), .state(state), .accept(accept), .req_ctl(req_ctl),
        .req_data(req_data), .dac_sel(dac_sel), .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n),
        .dac_data(dac_data), .dac_ldac_n(dac_ldac_n), .dac_clr_n(dac_clr_n)
    );

    assign req_ready = (state == ST_IDLE);
    assign busy      = !req_ready;

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy) else $error("accept"); // R10
    AST_CS_FOLLOWS_WR: assert property (@(posedge clk) disable iff (rst)
        (dac_cs_n == dac_wr_n)) else $error("cs"); // R5

endmodule

// File: tb/sim_pdac_write_seq.sv
module sim_pdac_write_seq;
    localparam int CLK_PERIOD = 10;
    localparam int unsigned CLK_PS = CLK_PERIOD * 1000;
    localparam int MAXT = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_chan = 1'b0, req_load = 1'b0, req_clear = 1'b0;
    logic [7:0] req_data = 8'h00;
    logic req_ready, busy, dac_sel, dac_cs_n, dac_wr_n, dac_ldac_n, dac_clr_n;
    logic [7:0] dac_data;

    int nchk = 0, nerr = 0, cyc_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdac_write_seq #(.DATA_W(8), .CLK_PS(CLK_PS)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_data(req_data), .req_load(req_load), .req_clear(req_clear),
        .busy(busy), .dac_sel(dac_sel), .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n),
        .dac_data(dac_data), .dac_ldac_n(dac_ldac_n), .dac_clr_n(dac_clr_n)
    );

    function automatic int cyc(input int t_ps);
        int n = (t_ps + int'(CLK_PS) - 1) / int'(CLK_PS);
        return (n < 1) ? 1 : n;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    int e_wl, e_h, e_w2l, e_ld, e_clr;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    logic t_wr[MAXT], t_cs[MAXT], t_ld[MAXT], t_clr[MAXT], t_sel[MAXT], t_busy[MAXT];
    logic [7:0] t_dat[MAXT];

    task automatic run_req(input logic ch, input logic [7:0] d, input logic ld, input logic cl);
        int n = 0;
        int bad_wr = 0, bad_cs = 0, bad_dat = 0, bad_sel = 0, bad_ld = 0, bad_busy = 0;
        int bad_clr = 0, fall_at = -1, ld_low = 0, exp_len;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_chan = ch; req_data = d; req_load = ld; req_clear = cl;
        @(negedge clk);
        req_valid = 1'b0; req_data = ~d; req_chan = ~ch; req_load = 1'b0; req_clear = 1'b0;
        while (!req_ready && n < MAXT) begin
            t_wr[n] = dac_wr_n; t_cs[n] = dac_cs_n; t_ld[n] = dac_ldac_n; t_clr[n] = dac_clr_n;
            t_sel[n] = dac_sel; t_dat[n] = dac_data; t_busy[n] = busy;
            n++;
            @(negedge clk);
        end
        chk(busy == 1'b0, "R11", "busy after sequence", busy, 0);
        if (cl) begin
            exp_len = e_clr;
            for (int i = 0; i < n; i++) begin
                if (t_clr[i] !== 1'b0) bad_clr++;
                if (t_wr[i] !== 1'b1 || t_cs[i] !== 1'b1 || t_ld[i] !== 1'b1) bad_wr++;
                if (t_busy[i] !== 1'b1) bad_busy++;
            end
            chk(bad_clr == 0, "R9", "clear low cycles mismatching", bad_clr, 0);
            chk(bad_wr == 0, "R9", "other strobes active during clear", bad_wr, 0);
        end else begin
            exp_len = e_wl + e_h + (ld ? (e_w2l - e_h) + e_ld : 0);
            for (int i = 0; i < n; i++) begin
                if (t_wr[i] !== ((i < e_wl) ? 1'b0 : 1'b1)) bad_wr++;
                if (t_cs[i] !== t_wr[i]) bad_cs++;
                if (i < e_wl + e_h && t_dat[i] !== d) bad_dat++;
                if (i < e_wl && t_sel[i] !== ch) bad_sel++;
                if (t_clr[i] !== 1'b1) bad_ld++;
                if (t_ld[i] === 1'b0) begin
                    ld_low++;
                    if (fall_at < 0) fall_at = i;
                end
                if (t_busy[i] !== 1'b1) bad_busy++;
            end
            chk(bad_wr == 0, "R2", "write low pattern mismatches", bad_wr, 0);
            chk(bad_cs == 0, "R5", "chip select vs write mismatches", bad_cs, 0);
            chk(bad_dat == 0, "R3/R6", "data bus mismatches (low+hold)", bad_dat, 0);
            chk(bad_sel == 0, "R4", "channel select mismatches", bad_sel, 0);
            chk(bad_ld == 0, "R9", "clear active during write", bad_ld, 0);
            if (ld) begin
                chk(fall_at == e_wl + e_w2l, "R7", "load fall cycle", fall_at, e_wl + e_w2l);
                chk(ld_low == e_ld, "R8", "load width", ld_low, e_ld);
            end else begin
                chk(ld_low == 0, "R7", "load cycles without load flag", ld_low, 0);
            end
        end
        chk(n == exp_len, "R10", "busy length", n, exp_len);
        chk(bad_busy == 0, "R11", "busy not inverse of ready", bad_busy, 0);
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc_cnt, 100000);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        e_wl  = imax(cyc(20000), cyc(15000));
        e_h   = cyc(4500);
        e_w2l = imax(cyc(20000), e_h);
        e_ld  = cyc(20000);
        e_clr = cyc(20000);
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        chk(dac_wr_n && dac_cs_n && dac_ldac_n && dac_clr_n, "R1", "strobes in reset",
            {dac_wr_n, dac_cs_n, dac_ldac_n, dac_clr_n}, 15);
        rst = 1'b0;
        @(negedge clk);
        chk(dac_wr_n && dac_cs_n && dac_ldac_n && dac_clr_n, "R1", "strobes after reset",
            {dac_wr_n, dac_cs_n, dac_ldac_n, dac_clr_n}, 15);
        chk(req_ready == 1'b1 && busy == 1'b0, "R1", "ready/busy after reset", {req_ready, busy}, 2);
        // directed: extremes, a simultaneous-update pair, a clear
        run_req(1'b0, 8'h00, 1'b0, 1'b0);
        run_req(1'b1, 8'hFF, 1'b0, 1'b0);
        run_req(1'b0, 8'hA5, 1'b0, 1'b0);
        run_req(1'b1, 8'h5A, 1'b1, 1'b0);
        run_req(1'b0, 8'h33, 1'b0, 1'b1);
        run_req(1'b1, 8'h81, 1'b1, 1'b0);
        for (int k = 0; k < 60; k++) begin
            logic [31:0] r = $urandom;
            run_req(r[0], r[15:8], r[1], (r[4:2] == 3'd0));
            repeat (r[7:5] % 3) @(negedge clk);
        end
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule